// File: doc/BRIEF.md
# Software Strap Configuration Latch

This block sits in the management side of a 10/100 Ethernet PHY and holds a strap word that a host writes after power-on reset. The PHY stays held in reset until the host sets the completion flag in that word. A rising edge on the flag makes a single-cycle internal reset pulse. On that pulse the block loads images of the basic mode control register, the advertisement register, the PHY control register and the LED control register. The values come from the decoded strap word, or from the hardware strap pins when software override is off. It then releases the PHY.

The host write channel is valid/ready. A write transfers on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low in the first cycle after reset, when the hardware straps are captured. It is also low in the cycle of the internal reset pulse, so a write can never race the load. While `wr_ready` is low, the host must hold `wr_valid`, `wr_addr` and `wr_data` steady.

Top module: `swstrap_latch`

## Requirements
- R1: After reset the strap word reads 0, `int_rst_pulse` and `phy_release` are 0 and `wr_ready` is 0. In the first cycle after reset, bits 14:10 of the strap word load from the hardware strap pins, and `wr_ready` then rises.
- R2: A write to address 0x09 sets the strap word from write-data bits 15:10. The fields are: bit 15 completion flag, bit 14 automatic crossover enable, bit 13 auto-negotiation enable, bits 12:11 mode, bit 10 LED select. Bits 9:0 read as 0.
- R3: A 0-to-1 change of the completion flag gives `int_rst_pulse` high for exactly one cycle, the cycle after the accepting edge. Writing the flag again as 1 gives no pulse. Clearing the flag and setting it again gives a new pulse.
- R4: With auto-negotiation disabled, the mode sets the forced link in the control image (bit 13 = 100 Mb/s, bit 8 = full duplex, bit 12 = 0). The encoding is 00 = 10 half, 01 = 10 full, 10 = 100 half, 11 = 100 full.
- R5: With auto-negotiation enabled, bit 12 of the control image is 1, and advertisement bits 8:5 (100 full, 100 half, 10 full, 10 half) are set as follows: 00 = 10 half+full, 01 = 100 half+full, 10 = 10 half + 100 half, 11 = all four.
- R6: In forced mode the advertisement image carries only the single forced ability. Under auto-negotiation the control image speed is 100 if any 100 ability is advertised, and duplex is full if a full ability is advertised at that speed. Advertisement bits 4:0 keep their value (reset 00001).
- R7: On the pulse, PHY control bit 15 takes the crossover enable and LED control bit 5 takes the LED select. All other bits of both images keep the values the host wrote.
- R8: When `strap_override` is 0, the loads on the pulse take their values from the hardware strap pins instead of the strap word.
- R9: `phy_release` rises on the edge that ends the pulse and stays high until reset.
- R10: Writes to the image addresses 0x00, 0x04, 0x18 and 0x19 replace the whole image. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Block can accept a write |
| wr_addr | input | 5 | Management register address |
| wr_data | input | 16 | Write data |
| strap_override | input | 1 | 1 = load from strap word, 0 = from hardware pins |
| hw_mdix_en | input | 1 | Hardware strap: automatic crossover enable |
| hw_an_en | input | 1 | Hardware strap: auto-negotiation enable |
| hw_an_mode | input | 2 | Hardware strap: mode |
| hw_led_sel | input | 1 | Hardware strap: LED select |
| strap_word | output | 16 | Current strap register |
| int_rst_pulse | output | 1 | One-cycle internal reset pulse |
| phy_release | output | 1 | PHY released from held reset |
| bmcr_img | output | 16 | Basic mode control image |
| anar_img | output | 16 | Advertisement image |
| phycr_img | output | 16 | PHY control image |
| ledcr_img | output | 16 | LED control image |

## Verification
The hardest situation to reach from the ports is the pulse cycle. It lasts one clock, and `wr_ready` is low throughout it. The bench aligns its samples to the negedge directly after the accepting edge to catch the pulse and the withheld ready. It also sweeps all eight enable/mode combinations under both override settings. In each run it places host-written values in the PHY control and LED images first, so that the load can be seen to overwrite only its own bits.

// File: rtl/swstrap_pkg.sv
package swstrap_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 5;

  typedef struct packed {
    logic       mdix;
    logic       anen;
    logic [1:0] mode;
    logic       led;
  } strap_t;

  // adv order: {100 full, 100 half, 10 full, 10 half}
  typedef struct packed {
    logic       speed100;
    logic       anen;
    logic       full;
    logic [3:0] adv;
  } link_cfg_t;

  function automatic link_cfg_t decode_link(input logic anen, input logic [1:0] mode);
    link_cfg_t c;
    c.anen = anen;
    if (!anen) begin
      c.speed100 = mode[1];
      c.full     = mode[0];
      c.adv      = 4'b0001 << mode;
    end else begin
      case (mode)
        2'b00:   c.adv = 4'b0011;
        2'b01:   c.adv = 4'b1100;
        2'b10:   c.adv = 4'b0101;
        default: c.adv = 4'b1111;
      endcase
      c.speed100 = c.adv[3] | c.adv[2];
      c.full     = c.speed100 ? c.adv[3] : c.adv[1];
    end
    return c;
  endfunction
endpackage

// File: rtl/swstrap_reg.sv
module swstrap_reg
  import swstrap_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter logic [AW-1:0] STRAP_ADDR = 'h09
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strap_t        hw_strap,
  input  logic          wr_fire,
  input  logic [AW-1:0] wr_addr,
  input  logic [5:0]    wr_hi,
  output logic          init_done,
  output logic          cfg_done,
  output strap_t        strap
);
  logic hit;
  assign hit = wr_fire && (wr_addr == STRAP_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_done <= 1'b0;
      cfg_done  <= 1'b0;
      strap     <= '0;
    end else if (!init_done) begin
      init_done <= 1'b1;
      strap     <= hw_strap;
    end else if (hit) begin
      cfg_done  <= wr_hi[5];
      strap     <= strap_t'(wr_hi[4:0]);
    end
  end

  a_r1_no_write_before_init: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !wr_fire);
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !hit) |=> $stable(strap) && $stable(cfg_done));
endmodule

// File: rtl/swstrap_pulse.sv
module swstrap_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_done,
  output logic pulse,
  output logic phy_release
);
  logic done_q;
  assign pulse = cfg_done & ~done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q      <= 1'b0;
      phy_release <= 1'b0;
    end else begin
      done_q <= cfg_done;
      if (pulse) phy_release <= 1'b1;
    end
  end

  a_r3_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  a_r3_pulse_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> cfg_done);
  a_r9_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    phy_release |=> phy_release);
  a_r9_release_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> phy_release);
endmodule

// File: rtl/swstrap_targets.sv
module swstrap_targets
  import swstrap_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int AW = ADDR_W,
  parameter logic [AW-1:0] BMCR_ADDR  = 'h00,
  parameter logic [AW-1:0] ANAR_ADDR  = 'h04,
  parameter logic [AW-1:0] LEDCR_ADDR = 'h18,
  parameter logic [AW-1:0] PHYCR_ADDR = 'h19,
  parameter logic [W-1:0]  ANAR_RST   = 'h0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          load,
  input  strap_t        src,
  output logic [W-1:0]  bmcr,
  output logic [W-1:0]  anar,
  output logic [W-1:0]  phycr,
  output logic [W-1:0]  ledcr
);
  localparam int N = 4;
  localparam logic [N-1:0][AW-1:0] ADDRS = {PHYCR_ADDR, LEDCR_ADDR, ANAR_ADDR, BMCR_ADDR};
  localparam logic [N-1:0][W-1:0]  RSTS  = {{W{1'b0}}, {W{1'b0}}, ANAR_RST, {W{1'b0}}};

  link_cfg_t lc;
  logic [N-1:0][W-1:0] mask, val, img;

  always_comb begin
    lc   = decode_link(src.anen, src.mode);
    mask = '0;
    val  = '0;
    mask[0][13] = 1'b1; val[0][13] = lc.speed100;
    mask[0][12] = 1'b1; val[0][12] = lc.anen;
    mask[0][8]  = 1'b1; val[0][8]  = lc.full;
    mask[1][8:5] = 4'hF; val[1][8:5] = lc.adv;
    mask[2][5]  = 1'b1; val[2][5]  = src.led;
    mask[3][15] = 1'b1; val[3][15] = src.mdix;
  end

  for (genvar i = 0; i < N; i++) begin : g_img
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        img[i] <= RSTS[i];
      else if (load)
        img[i] <= (img[i] & ~mask[i]) | (val[i] & mask[i]);
      else if (wr_fire && wr_addr == ADDRS[i])
        img[i] <= wr_data;
    end
  end

  assign bmcr  = img[0];
  assign anar  = img[1];
  assign ledcr = img[2];
  assign phycr = img[3];

  a_r7_mdix_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> phycr[15] == $past(src.mdix));
  a_r7_led_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ledcr[5] == $past(src.led));
  a_r7_phycr_rest_kept: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> phycr[14:0] == $past(phycr[14:0]));
  a_r6_selector_kept: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> anar[4:0] == $past(anar[4:0]));
  a_r10_no_write_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !wr_fire);
endmodule

// File: rtl/swstrap_latch.sv
module swstrap_latch
  import swstrap_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          strap_override,
  input  logic          hw_mdix_en,
  input  logic          hw_an_en,
  input  logic [1:0]    hw_an_mode,
  input  logic          hw_led_sel,
  output logic [W-1:0]  strap_word,
  output logic          int_rst_pulse,
  output logic          phy_release,
  output logic [W-1:0]  bmcr_img,
  output logic [W-1:0]  anar_img,
  output logic [W-1:0]  phycr_img,
  output logic [W-1:0]  ledcr_img
);
  localparam int LOW_W = W - 6;

  strap_t hw_strap, strap, src;
  logic   init_done, cfg_done, wr_fire;

  assign hw_strap = '{mdix: hw_mdix_en, anen: hw_an_en, mode: hw_an_mode, led: hw_led_sel};
  assign wr_ready = init_done & ~int_rst_pulse;
  assign wr_fire  = wr_valid & wr_ready;
  assign src      = strap_override ? strap : hw_strap;
  assign strap_word = {cfg_done, strap, {LOW_W{1'b0}}};

  swstrap_reg #(.AW(AW)) u_reg (
    .clk(clk), .rst_n(rst_n), .hw_strap(hw_strap), .wr_fire(wr_fire),
    .wr_addr(wr_addr), .wr_hi(wr_data[W-1:W-6]), .init_done(init_done),
    .cfg_done(cfg_done), .strap(strap)
  );

  swstrap_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done),
    .pulse(int_rst_pulse), .phy_release(phy_release)
  );

  swstrap_targets #(.W(W), .AW(AW)) u_tgt (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(int_rst_pulse), .src(src),
    .bmcr(bmcr_img), .anar(anar_img), .phycr(phycr_img), .ledcr(ledcr_img)
  );

  a_r10_ready_low_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst_pulse |-> !wr_ready);
  a_r1_no_release_without_done: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_release |-> !$past(int_rst_pulse));
endmodule

// File: tb/swstrap_latch_tb.sv
module swstrap_latch_tb;
  logic clk = 0, rst_n = 0, wr_valid = 0, wr_ready;
  logic [4:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic ovr = 0, hmdix = 0, hanen = 0, hled = 0;
  logic [1:0] hmode = '0;
  logic [15:0] sw, bmcr, anar, phycr, ledcr;
  logic pulse, rel;
  int checks = 0, errors = 0, pulses = 0;
  bit done = 0;

  always #5 clk = ~clk;

  swstrap_latch u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .strap_override(ovr),
    .hw_mdix_en(hmdix), .hw_an_en(hanen), .hw_an_mode(hmode), .hw_led_sel(hled),
    .strap_word(sw), .int_rst_pulse(pulse), .phy_release(rel),
    .bmcr_img(bmcr), .anar_img(anar), .phycr_img(phycr), .ledcr_img(ledcr)
  );

  always @(negedge clk) if (pulse) pulses++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_addr = a; wr_data = d; wr_valid = 1;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 0;
  endtask

  function automatic logic [3:0] adv_of(input logic an, input logic [1:0] m);
    if (!an) return 4'b0001 << m;
    return {m[0], (m != 2'b00), (m == 2'b00 || m == 2'b11), (m != 2'b01)};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int o = 0; o < 2; o++) begin
      for (int c = 0; c < 8; c++) begin
        logic an, mdx, led, e_an, e_mdx, e_led;
        logic [1:0] m, e_m;
        logic [3:0] adv;
        logic spd, dup;
        int p0;
        an = c[2]; m = c[1:0]; mdx = c[0] ^ c[1]; led = ~c[0];
        // hardware pins differ from the written word
        hanen = ~an; hmode = ~m; hmdix = ~mdx; hled = ~led; ovr = o[0];
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        chk("R1 ready", {15'b0, wr_ready}, 16'h0);
        chk("R1 strap", sw, 16'h0);
        chk("R1 pulse/release", {14'b0, pulse, rel}, 16'h0);
        @(negedge clk);
        chk("R1 hw capture", sw, {1'b0, hmdix, hanen, hmode, hled, 10'b0});
        chk("R1 ready up", {15'b0, wr_ready}, 16'h1);
        wr(5'h19, 16'h00ff);
        wr(5'h18, 16'h0040);
        wr(5'h05, 16'hffff);
        chk("R10 ignored", anar, 16'h0001);
        chk("R10 bmcr", bmcr, 16'h0);
        wr(5'h09, {1'b0, mdx, an, m, led, 10'h3ff});
        chk("R2 word", sw, {1'b0, mdx, an, m, led, 10'b0});
        p0 = pulses;
        wr(5'h09, {1'b1, mdx, an, m, led, 10'h0});
        chk("R3 pulse", {14'b0, pulse, wr_ready}, 16'h2);
        chk("R9 not yet", {15'b0, rel}, 16'h0);
        @(negedge clk);
        chk("R3 one cycle", {15'b0, pulse}, 16'h0);
        chk("R9 release", {15'b0, rel}, 16'h1);
        if (o == 1) begin e_an = an; e_m = m; e_mdx = mdx; e_led = led; end
        else begin e_an = hanen; e_m = hmode; e_mdx = hmdix; e_led = hled; end
        adv = adv_of(e_an, e_m);
        spd = adv[3] | adv[2];
        dup = spd ? adv[3] : adv[1];
        chk(e_an ? "R5 R6 bmcr" : "R4 bmcr", bmcr, {2'b0, spd, e_an, 3'b0, dup, 8'b0});
        chk(o == 1 ? (e_an ? "R5 anar" : "R6 anar") : "R8 anar", anar, {7'b0, adv, 5'b00001});
        chk("R7 phycr", phycr, {e_mdx, 15'h00ff});
        chk("R7 ledcr", ledcr, 16'h0040 | {10'b0, e_led, 5'b0});
        wr(5'h09, {1'b1, 5'b0, 10'h0});
        @(negedge clk);
        chk("R3 no repulse", pulses[15:0] - p0[15:0], 16'd1);
        wr(5'h09, 16'h0000);
        wr(5'h09, 16'h8000);
        @(negedge clk);
        chk("R3 new edge", pulses[15:0] - p0[15:0], 16'd2);
        chk("R9 sticky", {15'b0, rel}, 16'h1);
        wr(5'h00, 16'h1234);
        chk("R10 image write", bmcr, 16'h1234);
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule